// File: doc/BRIEF.md
# Wrapping Page Write Buffer

This block sits between the serial protocol controller of a byte-addressed non-volatile memory and its cell array. A write command opens with a start pulse that carries the target address. The buffer then takes data bytes one at a time into a 16-byte page store. Each incoming byte goes to the current in-page offset, and only that low offset advances. The page number stays fixed for the whole command. A run that passes the last byte of the page therefore continues at offset zero of the same page. When more bytes arrive than the page holds, the oldest bytes are overwritten in arrival order.

Nothing reaches the array until the command is closed by a stop pulse. At that point the buffer walks every offset of the page in ascending order. It raises an array write only for the slots that were filled during the current command, so all other bytes of the page keep their contents. It then holds its busy flag for a self-timed programming interval, which is modelled as a parameterised cycle count. While busy is high, any new command, byte or stop is ignored, which lets the controller withhold its acknowledge. A high write-protect level at the stop, a command that carried no data, and a command abandoned by a repeated start all end without array writes and without busy.

The controller is a four-state machine:
- ST_IDLE waits for a command.
- ST_COLLECT fills the page store.
- ST_DRAIN issues array writes, one offset per cycle.
- ST_PROGRAM waits out the programming timer.

Its transitions are:
- ST_IDLE to ST_COLLECT on a command start.
- ST_COLLECT to itself on a further start, which reloads the address and empties the store.
- ST_COLLECT to ST_IDLE on an abort, or on a stop that has no data or meets write protect.
- ST_COLLECT to ST_DRAIN on a stop with data and no protection.
- ST_DRAIN to ST_PROGRAM after the last offset.
- ST_PROGRAM to ST_IDLE when the timer expires.

Top module: `page_write_buffer`

## Requirements
- R1: While reset is asserted and after it is released, busy and arr_we are 0.
- R2: A data byte is stored at the address formed by the upper ADDR_W-4 bits of the command address (which never change during the command) and a 4-bit offset. The offset starts at the low 4 bits of the command address and advances by one after each byte.
- R3: A run that passes offset 15 continues at offset 0 of the same page, never in the next page.
- R4: With more than 16 bytes in one command, byte k and byte k+16 share an offset, and the later one is the one committed. At most 16 array writes result.
- R5: Array writes happen only after a stop that ends a command. One write is made per filled offset, in ascending offset order, and page bytes not written in the command keep their previous values.
- R6: A committing stop raises busy in the following cycle, and busy stays high for exactly PAGE_BYTES + PROG_CYCLES cycles.
- R7: If wp is 1 when the stop is taken, no array write occurs and busy stays 0.
- R8: A command with no data bytes, or one ended by cmd_abort, produces no array write and no busy.
- R9: While busy is 1, cmd_start, byte_valid and cmd_stop have no effect: the page written and the busy length are those of the earlier command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a write command begins at cmd_addr |
| cmd_addr | input | ADDR_W | Start address of the write command |
| byte_valid | input | 1 | Pulse: byte_data is a received data byte |
| byte_data | input | 8 | Data byte |
| cmd_stop | input | 1 | Pulse: stop closes the command and commits it |
| cmd_abort | input | 1 | Pulse: repeated start abandons the command |
| wp | input | 1 | Write protect, 1 inhibits the commit |
| busy | output | 1 | Commit in progress; the controller must not acknowledge |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The commit path is tried with the following data runs, each against a page image predicted from the address rules alone:
- A single byte, which isolates the simplest path.
- A short run from mid-page, which confirms the base offset is honoured.
- A second run into an already written page, which shows that only filled slots are rewritten.
- A run crossing offset 15, which tells an in-page wrap from a carry into the next page.
- A 20-byte run, which tells last-wins overwrite from first-wins.
- A full 16-byte run starting at the top of the address space.

Write-protected, empty and abandoned commands must leave both the array and busy untouched. A command issued during busy shows whether the ignore rule holds, both in the page contents and in the busy length.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DRAIN   = 2'd2,
        ST_PROGRAM = 2'd3
    } pwb_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/pwb_pointer.sv
module pwb_pointer #(
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-OFF_W-1:0] page_hi,
    output logic [OFF_W-1:0]  offset
);
    localparam int HI_W = ADDR_W - OFF_W;

    logic [HI_W-1:0]  hi_q;
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            off_q <= '0;
        end else if (load) begin
            hi_q  <= load_addr[ADDR_W-1:OFF_W];
            off_q <= load_addr[OFF_W-1:0];
        end else if (step) begin
            off_q <= off_q + 1'b1;
        end
    end

    assign page_hi = hi_q;
    assign offset  = off_q;

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> hi_q == $past(hi_q)); // R2
    AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> off_q == OFF_W'($past(off_q) + 1'b1)); // R3

endmodule

// File: rtl/pwb_page_store.sv
module pwb_page_store
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int OFF_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [BYTE_W-1:0]     slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_valid;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_data[g]  <= '0;
                slot_valid[g] <= 1'b0;
            end else if (clear) begin
                slot_valid[g] <= 1'b0;
            end else if (wr_en && wr_off == OFF_W'(g)) begin
                slot_data[g]  <= wr_data;
                slot_valid[g] <= 1'b1;
            end
        end
    end

    assign rd_data   = slot_data[rd_off];
    assign rd_valid  = slot_valid[rd_off];
    assign any_valid = |slot_valid;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !any_valid); // R8
    AST_FILL_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> any_valid); // R5

endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
    parameter int PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(PROG_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TICK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !start) |=> cnt_q == $past(cnt_q) - 1'b1); // R6

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int PAGE_BYTES  = 16,
    parameter int PROG_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cmd_stop,
    input  logic              cmd_abort,
    input  logic              wp,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int HI_W  = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    pwb_state_e state_q, state_d;
    logic [OFF_W-1:0]  drain_q;
    logic              ld_cmd, wr_byte, prog_start, prog_done;
    logic [HI_W-1:0]   page_hi;
    logic [OFF_W-1:0]  wr_off;
    logic [BYTE_W-1:0] rd_data;
    logic              rd_valid, any_valid;

    pwb_pointer #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ld_cmd), .load_addr(cmd_addr),
        .step(wr_byte), .page_hi(page_hi), .offset(wr_off)
    );

    pwb_page_store #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(ld_cmd), .wr_en(wr_byte),
        .wr_off(wr_off), .wr_data(byte_data), .rd_off(drain_q),
        .rd_data(rd_data), .rd_valid(rd_valid), .any_valid(any_valid)
    );

    pwb_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .expired(prog_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            drain_q <= '0;
        end else begin
            state_q <= state_d;
            drain_q <= (state_q == ST_DRAIN) ? drain_q + 1'b1 : '0;
        end
    end

    // Transitions and internal strobes
    always_comb begin
        state_d    = state_q;
        ld_cmd     = 1'b0;
        wr_byte    = 1'b0;
        prog_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) begin
                    ld_cmd  = 1'b1;
                    state_d = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (cmd_abort) begin
                    state_d = ST_IDLE;
                end else if (cmd_stop) begin
                    state_d = (any_valid && !wp) ? ST_DRAIN : ST_IDLE;
                end else if (cmd_start) begin
                    ld_cmd = 1'b1;
                end else if (byte_valid) begin
                    wr_byte = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (drain_q == LAST_OFF) begin
                    prog_start = 1'b1;
                    state_d    = ST_PROGRAM;
                end
            end
            ST_PROGRAM: begin
                if (prog_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state_q == ST_DRAIN) || (state_q == ST_PROGRAM);
        arr_we    = (state_q == ST_DRAIN) && rd_valid;
        arr_addr  = {page_hi, drain_q};
        arr_wdata = rd_data;
    end

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R5
    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && !cmd_abort && cmd_stop && wp) |=> !busy); // R7
    AST_NO_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && (cmd_abort || (cmd_stop && !any_valid))) |=> !busy); // R8
    AST_DRAIN_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |=> busy); // R6
    AST_IGNORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start) |=> state_q != ST_COLLECT); // R9

endmodule

// File: tb/page_write_buffer_bench.sv
`timescale 1ns/1ps
module page_write_buffer_bench;
    localparam int ADDR_W   = 10;
    localparam int PAGE     = 16;
    localparam int PROG     = 20;
    localparam int BUSY_LEN = PAGE + PROG;
    localparam int NVEC     = 8;

    // {addr[9:0], nbytes[4:0], seed[7:0], wp}
    localparam logic [23:0] VEC [NVEC] = '{
        {10'h010, 5'd1,  8'h11, 1'b0},
        {10'h025, 5'd4,  8'h21, 1'b0},
        {10'h028, 5'd2,  8'h31, 1'b0},
        {10'h03C, 5'd6,  8'h61, 1'b0},
        {10'h040, 5'd20, 8'h40, 1'b0},
        {10'h150, 5'd3,  8'h71, 1'b1},
        {10'h3F8, 5'd16, 8'h81, 1'b0},
        {10'h200, 5'd0,  8'h00, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, byte_valid = 1'b0, cmd_stop = 1'b0, cmd_abort = 1'b0, wp = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0] byte_data = '0;
    logic busy, arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0] arr_wdata;

    logic [7:0] arr_mem [1 << ADDR_W];
    logic [7:0] exp_mem [1 << ADDR_W];
    int we_cnt = 0, busy_cnt = 0;
    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    page_write_buffer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) u_page_write_buffer (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cmd_stop(cmd_stop),
        .cmd_abort(cmd_abort), .wp(wp), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    // Array model and activity counters, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << ADDR_W); i++) arr_mem[i] <= 8'hFF;
        end else begin
            if (arr_we) begin
                arr_mem[arr_addr] <= arr_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (busy) busy_cnt <= busy_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic send_cmd(input logic [ADDR_W-1:0] a);
        @(negedge clk); cmd_start = 1'b1; cmd_addr = a;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_data = d;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); cmd_abort = 1'b1;
        @(negedge clk); cmd_abort = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        repeat (2) @(negedge clk);
        while (busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic compare_page(input logic [ADDR_W-1:0] a, input string tag);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        for (int k = 0; k < PAGE; k++) begin
            logic [ADDR_W-1:0] ix;
            ix = {a[ADDR_W-1:4], 4'(k)};
            if (arr_mem[ix] !== exp_mem[ix]) begin
                if (bad == 0) begin
                    first_act = int'(arr_mem[ix]);
                    first_exp = int'(exp_mem[ix]);
                end
                bad++;
            end
        end
        check(bad == 0, tag, first_act, first_exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a;
        logic [4:0] n;
        logic [7:0] seed;
        logic w, commit;
        logic [3:0] off;
        int we0, b0, exp_we;

        for (int i = 0; i < (1 << ADDR_W); i++) exp_mem[i] = 8'hFF;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        check(arr_we == 1'b0, "R1 arr_we in reset", int'(arr_we), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1'b0 && arr_we == 1'b0, "R1 idle after reset", int'({busy, arr_we}), 0);

        // Vector table: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            a    = VEC[v][23:14];
            n    = VEC[v][13:9];
            seed = VEC[v][8:1];
            w    = VEC[v][0];
            wp   = w;
            we0  = we_cnt;
            b0   = busy_cnt;
            send_cmd(a);
            for (int i = 0; i < int'(n); i++) send_byte(seed + 8'(i));
            check(we_cnt == we0, "R5 no array write before stop", we_cnt - we0, 0);
            commit = (n != 0) && !w;
            if (commit) begin
                for (int i = 0; i < int'(n); i++) begin
                    off = a[3:0] + 4'(i);
                    exp_mem[{a[ADDR_W-1:4], off}] = seed + 8'(i);
                end
            end
            pulse_stop();
            wait_idle();
            check(busy_cnt - b0 == (commit ? BUSY_LEN : 0), "R6/R7/R8 busy length",
                  busy_cnt - b0, commit ? BUSY_LEN : 0);
            exp_we = commit ? ((int'(n) > PAGE) ? PAGE : int'(n)) : 0;
            check(we_cnt - we0 == exp_we, "R4/R5 array write count", we_cnt - we0, exp_we);
            compare_page(a, "R2/R3/R4/R5/R7 page contents");
            wp = 1'b0;
        end

        // R8: abandoned command then stop
        we0 = we_cnt;
        b0  = busy_cnt;
        send_cmd(10'h0A3);
        send_byte(8'h5A);
        send_byte(8'h5B);
        pulse_abort();
        pulse_stop();
        wait_idle();
        check(busy_cnt == b0, "R8 abort busy", busy_cnt - b0, 0);
        check(we_cnt == we0, "R8 abort writes", we_cnt - we0, 0);
        compare_page(10'h0A0, "R8 abort page untouched");

        // R9: command issued during busy is ignored
        we0 = we_cnt;
        b0  = busy_cnt;
        send_cmd(10'h080);
        send_byte(8'hA1);
        send_byte(8'hA2);
        exp_mem[10'h080] = 8'hA1;
        exp_mem[10'h081] = 8'hA2;
        pulse_stop();
        send_cmd(10'h082);
        send_byte(8'hE1);
        send_byte(8'hE2);
        send_byte(8'hE3);
        pulse_stop();
        wait_idle();
        check(busy_cnt - b0 == BUSY_LEN, "R9 busy not extended", busy_cnt - b0, BUSY_LEN);
        check(we_cnt - we0 == 2, "R9 write count", we_cnt - we0, 2);
        compare_page(10'h080, "R9 page holds first command only");
        check(busy == 1'b0, "R9 idle afterwards", int'(busy), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule